// File: doc/BRIEF.md
# Block-Descriptor Program Counter Sequencer

This block produces the instruction address stream for the execution side of a machine whose control flow is resolved ahead of time by a separate branch engine. It does not predict anything. The branch engine pushes block descriptors into a small queue inside the block. Each descriptor holds a start address and a length. The sequencer emits the start address. It then counts the length down one instruction word at a time and emits each following address. When the count reaches zero it takes the next descriptor.

Fetch can freeze the sequencer with a stall input, and a flush input discards every queued descriptor and the block in progress. When there is no work left, the address output is marked invalid and holds its last value until a new descriptor arrives.

Top module: `blk_pc_sequencer`

## Requirements
- R1: After reset `pcValid` is 0, `pcOut` is 0 and `enqFull` is 0.
- R2: A descriptor offered with `enqValid` high is stored when `enqFull` is low. `enqFull` rises in the cycle after the queue holds DEPTH (8) descriptors.
- R3: A descriptor offered while `enqFull` is high is dropped and never emitted, even if a dequeue happens in the same cycle.
- R4: In a cycle that is not stalled, with the remaining count zero and the queue not empty, the oldest descriptor is removed. On the next cycle `pcOut` equals its target, `pcValid` is 1, and the remaining count equals its length.
- R5: In a cycle that is not stalled, with a nonzero remaining count, `pcOut` rises by 4 and the count falls by one. A descriptor of length L therefore emits L+1 consecutive words, and length 0 emits only the target.
- R6: In a cycle that is not stalled, with the count zero and the queue empty, `pcValid` goes to 0 on the next cycle and `pcOut` keeps its value.
- R7: While `stall` is high (and `flush` low), `pcOut`, `pcValid` and the remaining count do not change, and no descriptor leaves the queue. Enqueue still works.
- R8: A cycle with `flush` high empties the queue, clears the remaining count and drives `pcValid` to 0 on the next cycle. A descriptor offered in that same cycle is dropped.
- R9: `flush` takes effect even when `stall` is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enqValid | input | 1 | Offer a descriptor this cycle |
| enqTarget | input | ADDR_W (32) | Block start address |
| enqLen | input | LEN_W (6) | Number of words that follow the start address |
| enqFull | output | 1 | Queue holds DEPTH descriptors; offers are dropped |
| stall | input | 1 | Freeze the sequencer for this cycle |
| flush | input | 1 | Discard queue contents and the current block |
| pcOut | output | ADDR_W (32) | Current instruction address |
| pcValid | output | 1 | `pcOut` is a real fetch address |

## Verification
Some checks are local to one cycle, and assertions cover these on every clock: a frozen state under stall, the 4-byte step while a block is in progress, the load of the head descriptor on dequeue, the invalid hold on an empty queue, an empty queue after flush, and an unchanged occupancy when a full queue is offered more data. Other behaviour only shows up across a whole scenario, and the bench's reference model checks it every cycle. This covers the exact ordering of blocks, the word count of each block including length 0, dropped descriptors never appearing later, and descriptors offered during a flush or a stall being lost or kept as required.

// File: rtl/blk_pc_seq_pkg.sv
package blk_pc_seq_pkg;

  // Strobes from the control module to the datapath and the queue.
  typedef struct packed {
    logic loadPc;    // take target/length from queue head
    logic stepPc;    // advance one word, count down
    logic clearCnt;  // drop the block in progress
    logic setValid;
    logic clrValid;
    logic deq;       // pop queue head
    logic flushQ;    // empty the queue
  } seq_ctl_t;

endpackage

// File: rtl/blk_desc_queue.sv
module blk_desc_queue #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 6,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enqValid,
  input  logic [ADDR_W-1:0] enqTarget,
  input  logic [LEN_W-1:0]  enqLen,
  input  logic              deq,
  input  logic              flushQ,
  output logic              full,
  output logic              empty,
  output logic [ADDR_W-1:0] headTarget,
  output logic [LEN_W-1:0]  headLen
);
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W  = PTR_W + 1;
  localparam int DESC_W = ADDR_W + LEN_W;

  logic [DESC_W-1:0] slots [DEPTH];
  logic [PTR_W-1:0]  rdPtr, wrPtr;
  logic [CNT_W-1:0]  count;
  logic              doEnq, doDeq;

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);
  assign doEnq = enqValid && !full && !flushQ;
  assign doDeq = deq && !empty && !flushQ;
  assign {headTarget, headLen} = slots[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    return p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (doEnq) slots[wrPtr] <= {enqTarget, enqLen};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else if (flushQ) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (doEnq) wrPtr <= nextPtr(wrPtr);
      if (doDeq) rdPtr <= nextPtr(rdPtr);
      case ({doEnq, doDeq})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (full && !deq && !flushQ) |=> (count == CNT_W'(DEPTH))); // R3
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    flushQ |=> empty); // R8
  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (count <= CNT_W'(DEPTH))); // R2

endmodule

// File: rtl/blk_seq_control.sv
module blk_seq_control
  import blk_pc_seq_pkg::*;
(
  input  logic     stall,
  input  logic     flush,
  input  logic     cntZero,
  input  logic     qEmpty,
  output seq_ctl_t ctl
);
  always_comb begin
    ctl = '0;
    if (flush) begin
      ctl.clearCnt = 1'b1;
      ctl.clrValid = 1'b1;
      ctl.flushQ   = 1'b1;
    end else if (!stall) begin
      if (!cntZero) begin
        ctl.stepPc   = 1'b1;
        ctl.setValid = 1'b1;
      end else if (!qEmpty) begin
        ctl.loadPc   = 1'b1;
        ctl.deq      = 1'b1;
        ctl.setValid = 1'b1;
      end else begin
        ctl.clrValid = 1'b1;
      end
    end
  end
endmodule

// File: rtl/blk_seq_datapath.sv
module blk_seq_datapath
  import blk_pc_seq_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 6,
  parameter int WORD_STEP = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_ctl_t          ctl,
  input  logic              stall,
  input  logic              flush,
  input  logic [ADDR_W-1:0] headTarget,
  input  logic [LEN_W-1:0]  headLen,
  output logic [ADDR_W-1:0] pcOut,
  output logic              pcValid,
  output logic              cntZero
);
  logic [ADDR_W-1:0] pcReg;
  logic [LEN_W-1:0]  remain;
  logic              validReg;

  assign pcOut   = pcReg;
  assign pcValid = validReg;
  assign cntZero = (remain == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcReg    <= '0;
      remain   <= '0;
      validReg <= 1'b0;
    end else begin
      if (ctl.clearCnt) begin
        remain <= '0;
      end else if (ctl.loadPc) begin
        pcReg  <= headTarget;
        remain <= headLen;
      end else if (ctl.stepPc) begin
        pcReg  <= pcReg + ADDR_W'(WORD_STEP);
        remain <= remain - LEN_W'(1);
      end
      if (ctl.clrValid)      validReg <= 1'b0;
      else if (ctl.setValid) validReg <= 1'b1;
    end
  end

  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (stall && !flush) |=> ($stable(pcReg) && $stable(remain) && $stable(validReg))); // R7
  AST_STEP_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && !flush && !cntZero) |=> (pcReg == $past(pcReg) + ADDR_W'(WORD_STEP))); // R5
  AST_FLUSH_INVALID: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (!validReg && cntZero)); // R8

endmodule

// File: rtl/blk_pc_sequencer.sv
module blk_pc_sequencer
  import blk_pc_seq_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 6,
  parameter int DEPTH     = 8,
  parameter int WORD_STEP = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enqValid,
  input  logic [ADDR_W-1:0] enqTarget,
  input  logic [LEN_W-1:0]  enqLen,
  output logic              enqFull,
  input  logic              stall,
  input  logic              flush,
  output logic [ADDR_W-1:0] pcOut,
  output logic              pcValid
);
  seq_ctl_t          ctl;
  logic              qEmpty, cntZero;
  logic [ADDR_W-1:0] headTarget;
  logic [LEN_W-1:0]  headLen;

  blk_desc_queue #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DEPTH(DEPTH)) uQueue (
    .clk(clk), .rstN(rstN), .enqValid(enqValid), .enqTarget(enqTarget),
    .enqLen(enqLen), .deq(ctl.deq), .flushQ(ctl.flushQ), .full(enqFull),
    .empty(qEmpty), .headTarget(headTarget), .headLen(headLen)
  );

  blk_seq_control uCtl (
    .stall(stall), .flush(flush), .cntZero(cntZero), .qEmpty(qEmpty), .ctl(ctl)
  );

  blk_seq_datapath #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .WORD_STEP(WORD_STEP)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .stall(stall), .flush(flush),
    .headTarget(headTarget), .headLen(headLen), .pcOut(pcOut),
    .pcValid(pcValid), .cntZero(cntZero)
  );

  AST_DEQ_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && !flush && cntZero && !qEmpty) |=> (pcValid && pcOut == $past(headTarget))); // R4
  AST_EMPTY_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && !flush && cntZero && qEmpty) |=> (!pcValid && $stable(pcOut))); // R6
  AST_FLUSH_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (stall && flush) |=> !pcValid); // R9

endmodule

// File: tb/sim_blk_pc_sequencer.sv
`timescale 1ns/1ps
module sim_blk_pc_sequencer;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 6;
  localparam int DEPTH  = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              enqValid = 1'b0;
  logic [ADDR_W-1:0] enqTarget = '0;
  logic [LEN_W-1:0]  enqLen = '0;
  logic              stall = 1'b0;
  logic              flush = 1'b0;
  logic              enqFull;
  logic [ADDR_W-1:0] pcOut;
  logic              pcValid;

  int checks = 0;
  int errors = 0;
  string curReq = "R1";

  always #2.5 clk = ~clk;

  blk_pc_sequencer u0 (
    .clk(clk), .rstN(rstN), .enqValid(enqValid), .enqTarget(enqTarget),
    .enqLen(enqLen), .enqFull(enqFull), .stall(stall), .flush(flush),
    .pcOut(pcOut), .pcValid(pcValid)
  );

  // Behavioural reference model
  logic [ADDR_W+LEN_W-1:0] mq[$];
  logic [ADDR_W-1:0] mPc = '0;
  int  mCnt = 0;
  bit  mValid = 0;
  bit  modelOn = 0;
  int  emitted = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mq.delete(); mPc = '0; mCnt = 0; mValid = 0;
    end else begin
      bit wasFull;
      wasFull = (mq.size() == DEPTH);
      if (pcValid && !stall && !flush) emitted++;
      if (flush) begin
        mq.delete(); mCnt = 0; mValid = 0;
      end else begin
        if (!stall) begin
          if (mCnt != 0) begin
            mPc = mPc + 4; mCnt--; mValid = 1;
          end else if (mq.size() > 0) begin
            logic [ADDR_W+LEN_W-1:0] d;
            d = mq.pop_front();
            mPc = d[ADDR_W+LEN_W-1:LEN_W]; mCnt = int'(d[LEN_W-1:0]); mValid = 1;
          end else begin
            mValid = 0;
          end
        end
        if (enqValid && !wasFull) mq.push_back({enqTarget, enqLen});
      end
    end
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (modelOn) begin
      check(pcValid == mValid, curReq, "pcValid", pcValid, mValid);
      if (mValid) check(pcOut == mPc, curReq, "pcOut", pcOut, mPc);
      check(enqFull == (mq.size() == DEPTH), curReq, "enqFull", enqFull, mq.size() == DEPTH);
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(logic [ADDR_W-1:0] t, int len);
    enqValid = 1; enqTarget = t; enqLen = LEN_W'(len);
    tick();
    enqValid = 0;
  endtask

  int expWords;

  initial begin
    tick(3);
    // R1 reset state
    check(pcValid == 0, "R1", "pcValid at reset", pcValid, 0);
    check(pcOut == 0, "R1", "pcOut at reset", pcOut, 0);
    check(enqFull == 0, "R1", "enqFull at reset", enqFull, 0);
    rstN = 1;
    modelOn = 1;
    tick(2);

    // R4 R5 blocks of mixed length, including length 0
    curReq = "R4";
    push(32'h0000_1000, 2);
    push(32'h0000_2000, 0);
    push(32'h0000_3000, 3);
    curReq = "R5";
    tick(12);
    // R6 idle after draining
    curReq = "R6";
    check(pcValid == 0, "R6", "pcValid idle", pcValid, 0);
    check(pcOut == 32'h0000_300C, "R6", "pcOut held", pcOut, 32'h0000_300C);

    // R2 R3 fill while stalled, extras dropped
    curReq = "R2";
    stall = 1;
    for (int i = 0; i < DEPTH; i++) push(32'h0001_0000 + 32'(i) * 32'h100, i % 3);
    check(enqFull == 1, "R2", "enqFull after DEPTH pushes", enqFull, 1);
    curReq = "R3";
    push(32'h00BA_D000, 5);
    push(32'h00BA_D100, 5);
    check(pcValid == 0, "R7", "no dequeue under stall", pcValid, 0);
    expWords = 0;
    for (int i = 0; i < DEPTH; i++) expWords += (i % 3) + 1;
    emitted = 0;
    stall = 0;
    // R3 offer while full in the very cycle the head leaves
    enqValid = 1; enqTarget = 32'h00BA_D200; enqLen = 1;
    tick();
    enqValid = 0;
    tick(expWords + 3);
    check(emitted == expWords, "R3", "words emitted after full", emitted, expWords);

    // R7 stall toggling mid-block
    curReq = "R7";
    push(32'h0002_0000, 9);
    for (int i = 0; i < 8; i++) begin stall = (i % 2 == 0); tick(); end
    stall = 1; tick(3); stall = 0;
    tick(12);

    // R8 flush mid-block with queued work and a same-cycle offer
    curReq = "R8";
    push(32'h0003_0000, 20);
    push(32'h0004_0000, 4);
    push(32'h0005_0000, 4);
    tick(3);
    flush = 1; enqValid = 1; enqTarget = 32'h0006_0000; enqLen = 2;
    tick();
    flush = 0; enqValid = 0;
    for (int i = 0; i < 4; i++) begin
      check(pcValid == 0, "R8", "pcValid after flush", pcValid, 0);
      tick();
    end

    // R9 flush while stalled
    curReq = "R9";
    push(32'h0007_0000, 6);
    tick(2);
    stall = 1; tick(); flush = 1; tick(); flush = 0;
    check(pcValid == 0, "R9", "pcValid after stalled flush", pcValid, 0);
    stall = 0; tick(3);
    check(pcValid == 0, "R9", "queue empty after stalled flush", pcValid, 0);

    // R4 back-to-back descriptors arriving into an idle sequencer
    curReq = "R4";
    push(32'h0008_0000, 0);
    push(32'h0009_0000, 1);
    push(32'h000A_0000, 0);
    tick(6);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule